// File: doc/BRIEF.md
# LIN Transceiver Power-Mode Controller

This block is the digital mode sequencer of a LIN physical-layer transceiver. It takes comparator outputs and pin levels that have already been digitised: supply above the turn-on level, supply below the turn-off level, regulator in regulation, chip-select/local-wake, the transmit-enable/fault pin, TXD, an internal fault flag and a bus-below-wake-threshold comparator. From these it moves among five modes: power-on reset, ready, operation, transmitter-off and power-down.

In each mode it drives enables for the regulator, the receiver, the transmitter, the bus pull-up, the watchdog and the bus-wake detector. It also drives an active-low reset output. A remote wake from power-down needs a filtered low on the bus followed by a return high. The filter length is set in clock cycles by `WAKE_FILT_CYC`.

Top module: `lin_pm_ctrl`

## Requirements
- R1: A high on `vbb_low_i` puts the controller in power-on reset (mode code 0) on the next clock edge, from any mode. In that mode every enable is low and `rst_no` is low. The asynchronous reset also enters this mode.
- R2: From power-on reset, `vbb_on_i` high with `vbb_low_i` low moves the controller to ready (code 1) on the next edge. Ready enables the regulator, the receiver and the watchdog. The transmitter stays off.
- R3: From ready (code 1) or transmitter-off (code 3), the controller enters operation (code 2) when all four of these are high: regulator-ok, chip-select, effective transmit-enable and TXD.
- R4: Effective transmit-enable is low when the pin is low or `int_fault_i` is high. From ready, chip-select high with effective transmit-enable low gives transmitter-off. In ready, chip-select low holds the mode.
- R5: In operation, a falling edge of chip-select gives power-down (code 4). Otherwise, a falling edge of effective transmit-enable while chip-select is high gives transmitter-off.
- R6: In transmitter-off, chip-select low gives power-down.
- R7: In power-down, chip-select high or a recognised bus wake gives ready. In power-down only the wake-detector enable is high.
- R8: A bus wake is recognised when the synchronised bus-low signal has been high for at least `WAKE_FILT_CYC` consecutive cycles and then falls. The low-time count clears when the bus returns high, so shorter lows never add up.
- R9: The bus pull-up is enabled only in operation. The watchdog is enabled only in ready and operation.
- R10: `tx_en_o` is high only in operation, and only while `reg_ok_i` is high and `int_fault_i` is low. It follows those two inputs in the same cycle.
- R11: Chip-select, the transmit-enable pin and bus-low each pass through a two-flop synchroniser. A change on one of them alters the mode on the third rising clock edge after the change. The other inputs act on the first edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| vbb_on_i | input | 1 | Supply above turn-on threshold |
| vbb_low_i | input | 1 | Supply below turn-off threshold |
| reg_ok_i | input | 1 | Regulator output within range |
| cs_i | input | 1 | Chip-select / local wake pin |
| txe_pin_i | input | 1 | Transmit-enable / fault pin level |
| txd_i | input | 1 | Transmit data pin |
| int_fault_i | input | 1 | Internal fault present |
| bus_low_i | input | 1 | Bus below wake threshold |
| mode_o | output | 3 | Current mode code (0..4) |
| reg_en_o | output | 1 | Regulator enable |
| rx_en_o | output | 1 | Receiver enable |
| tx_en_o | output | 1 | Transmitter enable |
| pullup_en_o | output | 1 | Bus pull-up enable |
| wdt_en_o | output | 1 | Watchdog enable |
| wake_det_en_o | output | 1 | Bus-wake detector enable |
| rst_no | output | 1 | Reset output, active low |

## Verification
The bench builds the block with `WAKE_FILT_CYC` set to 8. At that value a seven-cycle bus low and a full-length low can both be tried in a few cycles, and they land on either side of the wake threshold. Split lows of five cycles show that the count clears between them. A cycle-accurate reference model in the bench runs alongside random, biased pin activity. That activity reaches every mode transition, including supply drops mid-sequence and fault toggles during operation.

// File: rtl/lin_pm_pkg.sv
package lin_pm_pkg;
  typedef enum logic [2:0] {
    MODE_POR   = 3'd0,
    MODE_READY = 3'd1,
    MODE_OP    = 3'd2,
    MODE_TXOFF = 3'd3,
    MODE_PD    = 3'd4
  } mode_e;
endpackage

// File: rtl/lin_pm_sync.sv
module lin_pm_sync #(
  parameter int W = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  for (genvar g = 0; g < W; g++) begin : g_bit
    logic [1:0] ff_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) ff_q <= '0;
      else         ff_q <= {ff_q[0], d_i[g]};
    end
    assign q_o[g] = ff_q[1];
  end
endmodule

// File: rtl/lin_pm_wake_filt.sv
module lin_pm_wake_filt #(
  parameter int FILT = 8,
  localparam int CW = $clog2(FILT + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic low_i,
  output logic wake_o
);
  localparam logic [CW-1:0] FILT_C = CW'(FILT);

  logic [CW-1:0] cnt_q;
  logic          low_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      low_q <= 1'b0;
    end else begin
      low_q <= low_i;
      if (!en_i || !low_i)    cnt_q <= '0;
      else if (cnt_q < FILT_C) cnt_q <= cnt_q + 1'b1;
    end
  end

  // wake on the rising bus edge after a long enough low
  assign wake_o = en_i && low_q && !low_i && (cnt_q >= FILT_C);

  assert_cnt_step_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && low_i && cnt_q < FILT_C) |=> cnt_q == $past(cnt_q) + 1'b1);
  assert_cnt_clr_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !low_i |=> cnt_q == '0);
endmodule

// File: rtl/lin_pm_fsm.sv
module lin_pm_fsm
  import lin_pm_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  vbb_on_i,
  input  logic  vbb_low_i,
  input  logic  reg_ok_i,
  input  logic  cs_i,
  input  logic  txe_i,
  input  logic  txd_i,
  input  logic  wake_i,
  output mode_e st_o
);
  mode_e st_q, st_d;
  logic  cs_q, txe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= MODE_POR;
      cs_q  <= 1'b0;
      txe_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      cs_q  <= cs_i;
      txe_q <= txe_i;
    end
  end

  logic cs_fall, txe_fall, go_op;
  assign cs_fall  = cs_q & ~cs_i;
  assign txe_fall = txe_q & ~txe_i;
  assign go_op    = reg_ok_i & cs_i & txe_i & txd_i;

  always_comb begin
    st_d = st_q;
    if (vbb_low_i) st_d = MODE_POR;
    else begin
      unique case (st_q)
        MODE_POR:   if (vbb_on_i) st_d = MODE_READY;
        MODE_READY: if (go_op) st_d = MODE_OP;
                    else if (cs_i && !txe_i) st_d = MODE_TXOFF;
        MODE_OP:    if (cs_fall) st_d = MODE_PD;
                    else if (txe_fall && cs_i) st_d = MODE_TXOFF;
        MODE_TXOFF: if (!cs_i) st_d = MODE_PD;
                    else if (go_op) st_d = MODE_OP;
        MODE_PD:    if (cs_i || wake_i) st_d = MODE_READY;
        default:    st_d = MODE_POR;
      endcase
    end
  end

  assign st_o = st_q;

  assert_por_entry_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vbb_low_i |=> st_q == MODE_POR);
  assert_por_exit_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == MODE_POR && vbb_on_i && !vbb_low_i) |=> st_q == MODE_READY);
  assert_op_to_pd_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == MODE_OP && cs_fall && !vbb_low_i) |=> st_q == MODE_PD);
  assert_pd_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == MODE_PD && !cs_i && !wake_i && !vbb_low_i) |=> st_q == MODE_PD);
endmodule

// File: rtl/lin_pm_ctrl.sv
module lin_pm_ctrl
  import lin_pm_pkg::*;
#(
  parameter int WAKE_FILT_CYC = 8
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       vbb_on_i,
  input  logic       vbb_low_i,
  input  logic       reg_ok_i,
  input  logic       cs_i,
  input  logic       txe_pin_i,
  input  logic       txd_i,
  input  logic       int_fault_i,
  input  logic       bus_low_i,
  output logic [2:0] mode_o,
  output logic       reg_en_o,
  output logic       rx_en_o,
  output logic       tx_en_o,
  output logic       pullup_en_o,
  output logic       wdt_en_o,
  output logic       wake_det_en_o,
  output logic       rst_no
);
  logic [2:0] raw, syn;
  logic       cs_s, txe_s, bus_low_s, txe_eff, wake;
  mode_e      st;

  assign raw = {bus_low_i, txe_pin_i, cs_i};

  lin_pm_sync #(.W(3)) u_sync (
    .clk_i (clk_i), .rst_ni(rst_ni), .d_i(raw), .q_o(syn)
  );
  assign {bus_low_s, txe_s, cs_s} = syn;

  assign txe_eff = txe_s & ~int_fault_i;

  lin_pm_wake_filt #(.FILT(WAKE_FILT_CYC)) u_wake (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (st == MODE_PD),
    .low_i (bus_low_s),
    .wake_o(wake)
  );

  lin_pm_fsm u_fsm (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .vbb_on_i (vbb_on_i),
    .vbb_low_i(vbb_low_i),
    .reg_ok_i (reg_ok_i),
    .cs_i     (cs_s),
    .txe_i    (txe_eff),
    .txd_i    (txd_i),
    .wake_i   (wake),
    .st_o     (st)
  );

  logic active;
  assign active        = (st == MODE_READY) || (st == MODE_OP) || (st == MODE_TXOFF);
  assign mode_o        = st;
  assign reg_en_o      = active;
  assign rx_en_o       = active;
  assign tx_en_o       = (st == MODE_OP) && reg_ok_i && !int_fault_i;
  assign pullup_en_o   = (st == MODE_OP);
  assign wdt_en_o      = (st == MODE_READY) || (st == MODE_OP);
  assign wake_det_en_o = (st == MODE_PD);
  assign rst_no        = (st != MODE_POR);

  assert_tx_gate_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_en_o |-> (reg_en_o && rx_en_o && pullup_en_o));
  assert_rst_off_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rst_no |-> !(reg_en_o || rx_en_o || wdt_en_o || wake_det_en_o));
endmodule

// File: tb/lin_pm_ctrl_bench.sv
module lin_pm_ctrl_bench;
  localparam int FILT = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic vbb_on = 0, vbb_low = 0, reg_ok = 0, cs = 0, txe = 0, txd = 0, fault = 0, bus_low = 0;
  logic [2:0] mode;
  logic reg_en, rx_en, tx_en, pull_en, wdt_en, wake_en, rstn_out;

  int vectors = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  lin_pm_ctrl #(.WAKE_FILT_CYC(FILT)) u_lin_pm_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .vbb_on_i(vbb_on), .vbb_low_i(vbb_low),
    .reg_ok_i(reg_ok), .cs_i(cs), .txe_pin_i(txe), .txd_i(txd),
    .int_fault_i(fault), .bus_low_i(bus_low), .mode_o(mode),
    .reg_en_o(reg_en), .rx_en_o(rx_en), .tx_en_o(tx_en), .pullup_en_o(pull_en),
    .wdt_en_o(wdt_en), .wake_det_en_o(wake_en), .rst_no(rstn_out)
  );

  // {reg,rx,tx,pull,wdt,wake,rstn}
  function automatic logic [6:0] exp_out(input logic [2:0] m, input logic ok, input logic flt);
    case (m)
      3'd1:    return 7'b1100101;
      3'd2:    return {2'b11, ok & ~flt, 4'b1101};
      3'd3:    return 7'b1100001;
      3'd4:    return 7'b0000011;
      default: return 7'b0000000;
    endcase
  endfunction

  // reference model, cycle accurate from the requirements
  logic [2:0] m_mode;
  logic cs1, cs2, csq, tx1, tx2, txq, bl1, bl2, blq;
  int   m_cnt;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mode <= 3'd0; {cs1, cs2, csq, tx1, tx2, txq, bl1, bl2, blq} <= '0; m_cnt <= 0;
    end else begin
      logic te, csf, tef, go, wk, en;
      logic [2:0] nm;
      te  = tx2 & ~fault;
      csf = csq & ~cs2;
      tef = txq & ~te;
      go  = reg_ok & cs2 & te & txd;
      en  = (m_mode == 3'd4);
      wk  = en & blq & ~bl2 & (m_cnt >= FILT);
      nm  = m_mode;
      if (vbb_low) nm = 3'd0;
      else case (m_mode)
        3'd0: if (vbb_on) nm = 3'd1;
        3'd1: if (go) nm = 3'd2; else if (cs2 && !te) nm = 3'd3;
        3'd2: if (csf) nm = 3'd4; else if (tef && cs2) nm = 3'd3;
        3'd3: if (!cs2) nm = 3'd4; else if (go) nm = 3'd2;
        3'd4: if (cs2 || wk) nm = 3'd1;
        default: nm = 3'd0;
      endcase
      m_mode <= nm;
      m_cnt  <= (!en || !bl2) ? 0 : ((m_cnt < FILT) ? m_cnt + 1 : m_cnt);
      cs1 <= cs; cs2 <= cs1; csq <= cs2;
      tx1 <= txe; tx2 <= tx1; txq <= te;
      bl1 <= bus_low; bl2 <= bl1; blq <= bl2;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic [6:0] outs();
    return {reg_en, rx_en, tx_en, pull_en, wdt_en, wake_en, rstn_out};
  endfunction

  task automatic chk_mode(input string req, input logic [2:0] m);
    chk(req, {29'd0, mode}, {29'd0, m});
    chk({req, " outs"}, {25'd0, outs()}, {25'd0, exp_out(m, reg_ok, fault)});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog act=hung exp=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    @(negedge clk); @(negedge clk);
    chk_mode("R1 reset", 3'd0);
    rst_n = 1'b1;
    cyc(2);
    chk_mode("R1 por hold", 3'd0);
    vbb_on = 1'b1;
    cyc(1);
    chk_mode("R2 por->ready", 3'd1);
    // R11 latency on synchronised pins
    cs = 1; txe = 1; txd = 1; reg_ok = 1;
    cyc(2);
    chk_mode("R11 not yet", 3'd1);
    cyc(1);
    chk_mode("R3 ready->op", 3'd2);
    txe = 0;
    cyc(3);
    chk_mode("R5 txe fall->txoff", 3'd3);
    txe = 1;
    cyc(3);
    chk_mode("R3 txoff->op", 3'd2);
    fault = 1; #1;
    chk("R10 fault gates tx", {31'd0, tx_en}, 32'd0);
    cyc(1);
    chk_mode("R4 fault->txoff", 3'd3);
    fault = 0;
    cyc(1);
    chk_mode("R3 fault clear->op", 3'd2);
    reg_ok = 0; #1;
    chk("R10 reg not ok", {31'd0, tx_en}, 32'd0);
    cyc(1);
    chk_mode("R9 op stays", 3'd2);
    reg_ok = 1;
    cyc(1);
    chk("R10 tx on", {31'd0, tx_en}, 32'd1);
    cs = 0;
    cyc(3);
    chk_mode("R5 cs fall->pd", 3'd4);
    // R8 wake filter
    bus_low = 1; cyc(FILT - 1); bus_low = 0;
    cyc(5);
    chk_mode("R8 short low no wake", 3'd4);
    bus_low = 1; cyc(5); bus_low = 0; cyc(2); bus_low = 1; cyc(5); bus_low = 0;
    cyc(5);
    chk_mode("R8 split low no wake", 3'd4);
    bus_low = 1; cyc(FILT); bus_low = 0;
    cyc(2);
    chk_mode("R8 wake not yet", 3'd4);
    cyc(1);
    chk_mode("R7 bus wake->ready", 3'd1);
    txe = 0;
    cyc(4);
    chk_mode("R4 ready cs low holds", 3'd1);
    cs = 1;
    cyc(3);
    chk_mode("R4 ready->txoff", 3'd3);
    cs = 0;
    cyc(3);
    chk_mode("R6 txoff->pd", 3'd4);
    cs = 1;
    cyc(3);
    chk_mode("R7 cs wake->ready", 3'd1);
    vbb_low = 1;
    cyc(1);
    chk_mode("R1 supply drop", 3'd0);
    vbb_low = 0;
    cyc(1);
    chk("R1 model sync", {29'd0, mode}, {29'd0, m_mode});
    // constrained random against reference model (R1..R11)
    for (int s = 0; s < 250; s++) begin
      int hold;
      vbb_low = ($urandom % 25) == 0;
      vbb_on  = ($urandom % 8) != 0;
      reg_ok  = ($urandom % 6) != 0;
      cs      = ($urandom % 4) != 0;
      txe     = ($urandom % 4) != 0;
      txd     = ($urandom % 5) != 0;
      fault   = ($urandom % 10) == 0;
      bus_low = ($urandom % 2) == 0;
      hold    = 1 + ($urandom % 12);
      for (int k = 0; k < hold; k++) begin
        cyc(1);
        chk("R11 rand mode", {29'd0, mode}, {29'd0, m_mode});
        chk("R9 rand outs", {25'd0, outs()}, {25'd0, exp_out(m_mode, reg_ok, fault)});
      end
    end
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule